// File: doc/BRIEF.md
# Machine-Mode Trap and Return Sequencer

This block holds the machine-level control registers of a single-cycle 32-bit core and decides where execution goes next. Every clock edge retires one instruction. The core feeds the block the instruction word, its PC, the decoder's illegal flag and the branch outcome. The block then classifies the instruction as a plain operation, an environment call, a trap return or an unsupported privileged encoding.

On a trap, the block records the trapping PC, a cause code and the prior privilege state. It also raises privilege to machine level and steers fetch to the handler base. On a return, it steers fetch back to the saved PC and restores the earlier privilege and interrupt-enable state. A small status stack carries that state: a trap pushes it and a return pops it.

Software reaches the registers through one CSRRW-style port. The read is combinational and the write lands at the clock edge. A scratch register lets a handler park a general register on entry.

Top module: `trap_unit`

## Requirements
- R1: After synchronous reset, privilege is machine (`priv_o` = 2'b11) and the status word, handler base, saved PC, cause and scratch registers all read zero.
- R2: On a trap, the saved PC (0x341) takes the trapping PC with bits [1:0] cleared. The status field at bits [12:11] takes the prior privilege (00 user, 11 machine), and bit 7 takes the prior value of bit 3.
- R3: Cause codes are as follows. An environment call writes 8. It is opcode 0x73, bits [14:12] = 0, bits [31:20] = 0x000, with bits [19:15] and [11:7] zero. The illegal flag, any other encoding with opcode 0x73 and bits [14:12] = 0, and a user-mode return all write 2. The illegal flag wins over any decode. Cause is read at 0x342.
- R4: On a trap, in the same cycle `npc_o` equals the handler base (0x305) and `npc_sel_o` = 2. After the edge, status bit 3 is clear and privilege is machine.
- R5: A return is opcode 0x73 with bits [14:12] = 0, bits [31:20] = 0x302 and zero bits [19:15] and [11:7], executed at machine level. In the same cycle it gives `npc_o` = saved PC and `npc_sel_o` = 3. After the edge, bit 3 takes old bit 7, bit 7 is set, bits [12:11] become user, and privilege becomes the old [12:11] value.
- R6: A return executed at user level makes no return. It is an illegal-instruction trap, with the state updates of R2 and R4.
- R7: With no trap and no return, `npc_o` is `br_target_i` with `npc_sel_o` = 1 when `br_taken_i` is high, else PC+4 with `npc_sel_o` = 0. A system opcode with nonzero bits [14:12] is treated as a plain operation.
- R8: The CSR port reads, combinationally, the value at `csr_addr_i` before this cycle's update. When `csr_we_i` is high it writes `csr_wdata_i` at the edge. The addresses are status 0x300, handler base 0x305, scratch 0x340 (all 32 bits), saved PC 0x341 and cause 0x342. Any other address reads zero and ignores writes.
- R9: On a trap or return, `rd_block_o` is high and a CSR write presented in that cycle is discarded.
- R10: A status write keeps only bits 3, 7 and [12:11]; bits [12:11] store 11 when written 11 and 00 otherwise. Handler base and saved PC always read with bits [1:0] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction retires per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Retiring instruction word |
| pc_i | input | 32 | PC of the retiring instruction |
| illegal_i | input | 1 | Decoder marks the instruction illegal |
| br_taken_i | input | 1 | Branch or jump taken |
| br_target_i | input | 32 | Branch or jump target |
| csr_addr_i | input | 12 | CSR address for read and write |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data (pre-update value) |
| npc_o | output | 32 | Next PC |
| npc_sel_o | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 trap, 3 return |
| rd_block_o | output | 1 | Suppress destination-register write |
| priv_o | output | 2 | Current privilege: 00 user, 11 machine |

## Verification
`npc_o`, `npc_sel_o` and `rd_block_o` are combinational, so they are due in the cycle the instruction is presented. The bench compares them 1 ns after driving the inputs at the falling edge, before the rising edge that retires the instruction. Register effects such as cause, saved PC, status, scratch and privilege appear one edge later. The bench reads them through the CSR port at the next falling edge, with a harmless instruction presented so that the read itself changes nothing.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int XLEN    = 32;
    localparam int CSR_AW  = 12;
    localparam int ILEN    = 32;

    localparam logic [6:0]        OPC_SYSTEM = 7'h73;
    localparam logic [2:0]        F3_PRIV    = 3'b000;
    localparam logic [11:0]       F12_ECALL  = 12'h000;
    localparam logic [11:0]       F12_MRET   = 12'h302;

    localparam logic [CSR_AW-1:0] A_STATUS   = 12'h300;
    localparam logic [CSR_AW-1:0] A_HBASE    = 12'h305;
    localparam logic [CSR_AW-1:0] A_SCRATCH  = 12'h340;
    localparam logic [CSR_AW-1:0] A_SAVEPC   = 12'h341;
    localparam logic [CSR_AW-1:0] A_CAUSE    = 12'h342;

    localparam int B_IE      = 3;
    localparam int B_PIE     = 7;
    localparam int B_PPRIV   = 11;

    localparam logic [XLEN-1:0] CAUSE_ILLEGAL = XLEN'(2);
    localparam logic [XLEN-1:0] CAUSE_ECALL   = XLEN'(8);
    localparam logic [XLEN-1:0] PC_STEP       = XLEN'(4);

    typedef enum logic [1:0] {PRIV_U = 2'b00, PRIV_M = 2'b11} priv_e;
    typedef enum logic [1:0] {NPC_SEQ = 2'd0, NPC_BRANCH = 2'd1,
                              NPC_TRAP = 2'd2, NPC_RET = 2'd3} npc_sel_e;
    typedef enum logic [1:0] {SYS_NONE, SYS_ECALL, SYS_MRET, SYS_BAD} sys_kind_e;

    typedef struct packed {
        priv_e pprev;
        logic  pie;
        logic  ie;
    } status_t;

    typedef struct packed {
        logic            trap;
        logic            ret;
        logic [XLEN-1:0] cause;
    } action_t;

    function automatic sys_kind_e classify(input logic [ILEN-1:0] ins);
        sys_kind_e k;
        k = SYS_NONE;
        if (ins[6:0] == OPC_SYSTEM && ins[14:12] == F3_PRIV) begin
            if (ins[19:15] != 5'd0 || ins[11:7] != 5'd0) k = SYS_BAD;
            else if (ins[31:20] == F12_ECALL)            k = SYS_ECALL;
            else if (ins[31:20] == F12_MRET)             k = SYS_MRET;
            else                                         k = SYS_BAD;
        end
        return k;
    endfunction

    function automatic logic [XLEN-1:0] status_to_word(input status_t s);
        logic [XLEN-1:0] w;
        w = '0;
        w[B_IE]              = s.ie;
        w[B_PIE]             = s.pie;
        w[B_PPRIV+1:B_PPRIV] = s.pprev;
        return w;
    endfunction

    function automatic status_t word_to_status(input logic [XLEN-1:0] w);
        status_t s;
        s.ie    = w[B_IE];
        s.pie   = w[B_PIE];
        s.pprev = (w[B_PPRIV+1:B_PPRIV] == 2'b11) ? PRIV_M : PRIV_U;
        return s;
    endfunction

    function automatic status_t status_push(input status_t s, input priv_e cur);
        status_t r;
        r.pprev = cur;
        r.pie   = s.ie;
        r.ie    = 1'b0;
        return r;
    endfunction

    function automatic status_t status_pop(input status_t s);
        status_t r;
        r.ie    = s.pie;
        r.pie   = 1'b1;
        r.pprev = PRIV_U;
        return r;
    endfunction
endpackage

// File: rtl/trap_decode.sv
module trap_decode
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ILEN-1:0]   instr_i,
    input  logic              illegal_i,
    input  priv_e             priv_i,
    output action_t           act_o
);
    sys_kind_e kind;

    always_comb begin
        kind  = classify(instr_i);
        act_o = '0;
        if (illegal_i) begin
            act_o.trap  = 1'b1;
            act_o.cause = CAUSE_ILLEGAL;
        end else begin
            unique case (kind)
                SYS_ECALL: begin
                    act_o.trap  = 1'b1;
                    act_o.cause = CAUSE_ECALL;
                end
                SYS_MRET: begin
                    if (priv_i == PRIV_M) act_o.ret = 1'b1;
                    else begin
                        act_o.trap  = 1'b1;
                        act_o.cause = CAUSE_ILLEGAL;
                    end
                end
                SYS_BAD: begin
                    act_o.trap  = 1'b1;
                    act_o.cause = CAUSE_ILLEGAL;
                end
                default: ;
            endcase
        end
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_o.trap, act_o.ret}));                       // R9
    AST_ILLEGAL_FLAG_WINS: assert property (@(posedge clk) disable iff (rst)
        illegal_i |-> (act_o.trap && act_o.cause == CAUSE_ILLEGAL)); // R3
endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  action_t           act_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic              csr_we_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic [XLEN-1:0]   hbase_o,
    output logic [XLEN-1:0]   savepc_o,
    output priv_e             priv_o
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    status_t         st_q;
    priv_e           priv_q;
    logic [XLEN-1:0] hbase_q, savepc_q, cause_q, scratch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '{pprev: PRIV_U, pie: 1'b0, ie: 1'b0};
            priv_q    <= PRIV_M;
            hbase_q   <= '0;
            savepc_q  <= '0;
            cause_q   <= '0;
            scratch_q <= '0;
        end else if (act_i.trap) begin
            savepc_q <= pc_i & ALIGN_MASK;
            cause_q  <= act_i.cause;
            st_q     <= status_push(st_q, priv_q);
            priv_q   <= PRIV_M;
        end else if (act_i.ret) begin
            st_q   <= status_pop(st_q);
            priv_q <= st_q.pprev;
        end else if (csr_we_i) begin
            unique case (csr_addr_i)
                A_STATUS:  st_q      <= word_to_status(csr_wdata_i);
                A_HBASE:   hbase_q   <= csr_wdata_i & ALIGN_MASK;
                A_SCRATCH: scratch_q <= csr_wdata_i;
                A_SAVEPC:  savepc_q  <= csr_wdata_i & ALIGN_MASK;
                A_CAUSE:   cause_q   <= csr_wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (csr_addr_i)
            A_STATUS:  csr_rdata_o = status_to_word(st_q);
            A_HBASE:   csr_rdata_o = hbase_q;
            A_SCRATCH: csr_rdata_o = scratch_q;
            A_SAVEPC:  csr_rdata_o = savepc_q;
            A_CAUSE:   csr_rdata_o = cause_q;
            default:   csr_rdata_o = '0;
        endcase
    end

    assign hbase_o  = hbase_q;
    assign savepc_o = savepc_q;
    assign priv_o   = priv_q;

    AST_TRAP_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
        act_i.trap |=> savepc_q[XLEN-1:2] == $past(pc_i[XLEN-1:2]));     // R2
    AST_TRAP_SAVES_PRIV: assert property (@(posedge clk) disable iff (rst)
        act_i.trap |=> (st_q.pprev == $past(priv_q) && st_q.pie == $past(st_q.ie))); // R2
    AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        act_i.trap |=> (priv_q == PRIV_M && !st_q.ie));                  // R4
    AST_RET_POPS: assert property (@(posedge clk) disable iff (rst)
        act_i.ret |=> (st_q.ie == $past(st_q.pie) && st_q.pie && st_q.pprev == PRIV_U)); // R5
    AST_RET_ONLY_MACHINE: assert property (@(posedge clk) disable iff (rst)
        act_i.ret |-> priv_q == PRIV_M);                                 // R6
    AST_TRAP_DROPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (act_i.trap || act_i.ret) |=> $stable(scratch_q));              // R9
    AST_ALIGNED_BASES: assert property (@(posedge clk) disable iff (rst)
        (hbase_q[1:0] == 2'b00 && savepc_q[1:0] == 2'b00));             // R10
endmodule

// File: rtl/trap_pc_sel.sv
module trap_pc_sel
    import trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  action_t         act_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            br_taken_i,
    input  logic [XLEN-1:0] br_target_i,
    input  logic [XLEN-1:0] hbase_i,
    input  logic [XLEN-1:0] savepc_i,
    output logic [XLEN-1:0] npc_o,
    output npc_sel_e        sel_o
);
    always_comb begin
        if (act_i.trap)      sel_o = NPC_TRAP;
        else if (act_i.ret)  sel_o = NPC_RET;
        else if (br_taken_i) sel_o = NPC_BRANCH;
        else                 sel_o = NPC_SEQ;
    end

    always_comb begin
        unique case (sel_o)
            NPC_TRAP:   npc_o = hbase_i;
            NPC_RET:    npc_o = savepc_i;
            NPC_BRANCH: npc_o = br_target_i;
            default:    npc_o = pc_i + PC_STEP;
        endcase
    end

    AST_TRAP_TO_BASE: assert property (@(posedge clk) disable iff (rst)
        act_i.trap |-> npc_o == hbase_i);                                // R4
    AST_RET_TO_SAVED: assert property (@(posedge clk) disable iff (rst)
        act_i.ret |-> npc_o == savepc_i);                                // R5
    AST_PLAIN_FLOW: assert property (@(posedge clk) disable iff (rst)
        (!act_i.trap && !act_i.ret && !br_taken_i) |-> npc_o == pc_i + PC_STEP); // R7
endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ILEN-1:0]   instr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              illegal_i,
    input  logic              br_taken_i,
    input  logic [XLEN-1:0]   br_target_i,
    input  logic [CSR_AW-1:0] csr_addr_i,
    input  logic              csr_we_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic [XLEN-1:0]   npc_o,
    output logic [1:0]        npc_sel_o,
    output logic              rd_block_o,
    output logic [1:0]        priv_o
);
    action_t         act;
    priv_e           priv;
    npc_sel_e        sel;
    logic [XLEN-1:0] hbase, savepc;

    trap_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .instr_i   (instr_i),
        .illegal_i (illegal_i),
        .priv_i    (priv),
        .act_o     (act)
    );

    trap_csr_file u_csr (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .pc_i        (pc_i),
        .csr_addr_i  (csr_addr_i),
        .csr_we_i    (csr_we_i),
        .csr_wdata_i (csr_wdata_i),
        .csr_rdata_o (csr_rdata_o),
        .hbase_o     (hbase),
        .savepc_o    (savepc),
        .priv_o      (priv)
    );

    trap_pc_sel u_pcsel (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .pc_i        (pc_i),
        .br_taken_i  (br_taken_i),
        .br_target_i (br_target_i),
        .hbase_i     (hbase),
        .savepc_i    (savepc),
        .npc_o       (npc_o),
        .sel_o       (sel)
    );

    assign npc_sel_o  = sel;
    assign rd_block_o = act.trap | act.ret;
    assign priv_o     = priv;

    AST_BLOCK_ON_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (npc_sel_o == 2'd2 || npc_sel_o == 2'd3) |-> rd_block_o);        // R9
endmodule

// File: tb/tb_trap_unit.sv
`timescale 1ns/1ps
module tb_trap_unit;
    localparam logic [31:0] NOP   = 32'h0000_0013;
    localparam logic [31:0] ECALL = 32'h0000_0073;
    localparam logic [31:0] MRET  = 32'h3020_0073;
    localparam logic [31:0] BADP  = 32'h1050_0073;
    localparam logic [31:0] CSRW  = 32'h3400_1073;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc;
        logic        ill;
        logic        bt;
        logic [31:0] tgt;
        logic [1:0]  sel;
        logic [31:0] npc;
        logic [31:0] cause;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{NOP,   32'h10,  1'b0, 1'b0, 32'h0,  2'd0, 32'h14,  32'd0},
        '{NOP,   32'h14,  1'b0, 1'b1, 32'h80, 2'd1, 32'h80,  32'd0},
        '{ECALL, 32'h80,  1'b0, 1'b0, 32'h0,  2'd2, 32'h200, 32'd8},
        '{BADP,  32'h200, 1'b0, 1'b0, 32'h0,  2'd2, 32'h200, 32'd2},
        '{ECALL, 32'h204, 1'b0, 1'b0, 32'h0,  2'd2, 32'h200, 32'd8},
        '{NOP,   32'h208, 1'b1, 1'b1, 32'h90, 2'd2, 32'h200, 32'd2},
        '{ECALL, 32'h20C, 1'b0, 1'b0, 32'h0,  2'd2, 32'h200, 32'd8},
        '{ECALL, 32'h210, 1'b1, 1'b0, 32'h0,  2'd2, 32'h200, 32'd2},
        '{NOP,   32'h300, 1'b0, 1'b0, 32'h0,  2'd0, 32'h304, 32'd2},
        '{CSRW,  32'h304, 1'b0, 1'b0, 32'h0,  2'd0, 32'h308, 32'd2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr_i, pc_i, br_target_i, csr_wdata_i;
    logic        illegal_i, br_taken_i, csr_we_i;
    logic [11:0] csr_addr_i;
    logic [31:0] csr_rdata_o, npc_o;
    logic [1:0]  npc_sel_o, priv_o;
    logic        rd_block_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    trap_unit dut (
        .clk(clk), .rst(rst), .instr_i(instr_i), .pc_i(pc_i),
        .illegal_i(illegal_i), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
        .csr_addr_i(csr_addr_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
        .csr_rdata_o(csr_rdata_o), .npc_o(npc_o), .npc_sel_o(npc_sel_o),
        .rd_block_o(rd_block_o), .priv_o(priv_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic set_idle();
        instr_i = NOP; pc_i = 32'h1000; illegal_i = 1'b0; br_taken_i = 1'b0;
        br_target_i = '0; csr_we_i = 1'b0; csr_wdata_i = '0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        set_idle();
        csr_addr_i = a; csr_we_i = 1'b1; csr_wdata_i = d;
        @(posedge clk); #1;
        csr_we_i = 1'b0;
    endtask

    task automatic csr_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        set_idle();
        csr_addr_i = a;
        #1 check(req, csr_rdata_o, exp);
    endtask

    // drives one instruction, checks the same-cycle outputs, lets it retire
    task automatic exec(input logic [31:0] ins, input logic [31:0] pc, input logic ill,
                        input logic bt, input logic [31:0] tgt, input logic [1:0] esel,
                        input logic [31:0] enpc, input string req);
        @(negedge clk);
        instr_i = ins; pc_i = pc; illegal_i = ill; br_taken_i = bt; br_target_i = tgt;
        #1;
        check(req, 32'(npc_sel_o), 32'(esel));
        check(req, npc_o, enpc);
        check(req, 32'(rd_block_o), 32'(esel >= 2'd2));
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        set_idle();
        csr_addr_i = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1 check("R1 priv", 32'(priv_o), 32'h3);
        csr_chk(12'h300, 32'h0, "R1 status");
        csr_chk(12'h305, 32'h0, "R1 hbase");
        csr_chk(12'h340, 32'h0, "R1 scratch");
        csr_chk(12'h341, 32'h0, "R1 savepc");
        csr_chk(12'h342, 32'h0, "R1 cause");

        // R8 / R10 CSR port
        csr_wr(12'h305, 32'h0000_0203);
        csr_chk(12'h305, 32'h0000_0200, "R10 hbase align");
        csr_wr(12'h340, 32'hDEAD_BEEF);
        csr_chk(12'h340, 32'hDEAD_BEEF, "R8 scratch");
        csr_wr(12'h7C0, 32'h1234_5678);
        csr_chk(12'h7C0, 32'h0, "R8 unknown addr");
        csr_wr(12'h341, 32'h0000_0123);
        csr_chk(12'h341, 32'h0000_0120, "R10 savepc align");
        csr_wr(12'h300, 32'hFFFF_FFFF);
        csr_chk(12'h300, 32'h0000_1888, "R10 status mask");
        csr_wr(12'h300, 32'h0000_1000);
        csr_chk(12'h300, 32'h0000_0000, "R10 pprev illegal value");

        // table: R3 R4 R7, cause checked after each retirement
        for (int i = 0; i < NV; i++) begin
            exec(TBL[i].instr, TBL[i].pc, TBL[i].ill, TBL[i].bt, TBL[i].tgt,
                 TBL[i].sel, TBL[i].npc, "R7/R4 vector");
            csr_chk(12'h342, TBL[i].cause, "R3 cause vector");
        end
        csr_chk(12'h341, 32'h0000_0210, "R2 savepc after trap");

        // R5 return to user
        csr_wr(12'h300, 32'h0000_0080);
        csr_wr(12'h341, 32'h0000_0400);
        exec(MRET, 32'h50, 1'b0, 1'b0, 32'h0, 2'd3, 32'h400, "R5 return");
        #1 check("R5 priv user", 32'(priv_o), 32'h0);
        csr_chk(12'h300, 32'h0000_0088, "R5 status pop");

        // R6 return from user is an illegal trap
        exec(MRET, 32'h404, 1'b0, 1'b0, 32'h0, 2'd2, 32'h200, "R6 user return");
        #1 check("R6 priv machine", 32'(priv_o), 32'h3);
        csr_chk(12'h342, 32'd2, "R6 cause");
        csr_chk(12'h341, 32'h0000_0404, "R2 savepc");
        csr_chk(12'h300, 32'h0000_0080, "R2 status push from user");

        // R9 CSR write during trap discarded
        @(negedge clk);
        instr_i = ECALL; pc_i = 32'h600; illegal_i = 1'b0; br_taken_i = 1'b0;
        csr_addr_i = 12'h340; csr_we_i = 1'b1; csr_wdata_i = 32'h0000_1234;
        #1 check("R9 rd_block", 32'(rd_block_o), 32'h1);
        @(posedge clk); #1;
        csr_chk(12'h340, 32'hDEAD_BEEF, "R9 scratch kept");
        csr_chk(12'h342, 32'd8, "R3 ecall cause");
        csr_chk(12'h300, 32'h0000_1800, "R4 status push from machine");

        // R5 return with pprev machine keeps machine
        exec(MRET, 32'h604, 1'b0, 1'b0, 32'h0, 2'd3, 32'h600, "R5 return machine");
        #1 check("R5 priv stays machine", 32'(priv_o), 32'h3);
        csr_chk(12'h300, 32'h0000_0080, "R5 status pop machine");

        // R3 nonzero rd field on privileged encoding is unsupported
        exec(32'h0000_00F3, 32'h700, 1'b0, 1'b0, 32'h0, 2'd2, 32'h200, "R3 rd field");
        csr_chk(12'h342, 32'd2, "R3 rd field cause");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule